// File: doc/BRIEF.md
# Word-Serial Descriptor Ring Queue

This block is the per-channel queue between a host processor and a DMA engine. The host builds each transfer descriptor by writing four 32-bit words, one after another, to a single write port. The block counts the words internally and commits a complete descriptor into a four-entry ring only after the last word arrives. The engine sees the oldest committed descriptor as one parallel record and removes it with a single pop strobe.

A second ring runs the other way and carries completion reports. The engine pushes a report as one parallel record. The host drains it four words at a time from a single read port, and the entry is released after the fourth word has been read.

Each ring exposes its state in one packed status word: write slot, read slot, empty, full and a sticky error flag. Because occupancy is taken from the slots, equal slot values mean either empty or full, and the two flags tell those cases apart. A control bit resets both rings. Setting it and then clearing it returns both rings to the empty state and discards any partly written descriptor.

Top module: `desc_ring_queue`

## Requirements
- R1: After reset both status words read 0x0000_0100 (slots 0, empty set, full and error clear), `cons_valid` is 0 and `rpt_rdata` is 0.
- R2: Descriptor words are taken in the order address low, address high, length, flags. Nothing is committed before the fourth word. After the fourth word the consumer record shows `cons_addr` = {high, low}, `cons_len` and `cons_flags`.
- R3: Status word layout: write slot in bits [1:0], read slot in bits [5:4], empty in bit 8, full in bit 9, error in bit 10. All other bits are 0.
- R4: Each ring holds at most four entries and sets full at four. When the slots differ, occupancy is (wr + 4 - rd) mod 4. When they are equal, full means 4 and empty means 0.
- R5: A descriptor word written while the ring is full sets the error bit and is otherwise ignored: it neither advances the word position nor alters any entry.
- R6: The error bit is sticky. Writing a status word with bit 10 set clears it. Writing with bit 10 clear leaves it unchanged.
- R7: A consumer pop on an empty ring has no effect. A pop in the same cycle as a commit into an empty ring is ignored, and the committed entry stays.
- R8: Writing control bit 0 to 1 and then to 0 leaves both rings empty with both slots 0. A partly written descriptor is discarded, so the next word is taken as address low.
- R9: A pushed report is read back from `rpt_rdata` as count low, count high, auxiliary, flags on four successive reads. The entry is released after the fourth read.
- R10: A report read while the report ring is empty returns 0 and sets the report error bit. A report push while that ring is full is dropped and sets the report error bit.
- R11: Entries leave each ring in the order they entered, including across slot wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data; bit 0 is the ring reset |
| dsc_we | input | 1 | Descriptor word write strobe |
| dsc_wdata | input | 32 | Descriptor word |
| dsc_stat_we | input | 1 | Descriptor status write strobe (error clear) |
| dsc_stat_wdata | input | 32 | Descriptor status write data; bit 10 clears the error |
| dsc_status | output | 32 | Descriptor ring status word |
| cons_pop | input | 1 | Consumer removes the head descriptor |
| cons_valid | output | 1 | A descriptor is available at the head |
| cons_addr | output | 64 | Head descriptor address |
| cons_len | output | 32 | Head descriptor length |
| cons_flags | output | 32 | Head descriptor flags |
| rpt_push | input | 1 | Engine pushes one report record |
| rpt_count | input | 64 | Report count value |
| rpt_aux | input | 32 | Report auxiliary word |
| rpt_flags | input | 32 | Report flags |
| rpt_re | input | 1 | Host report word read strobe |
| rpt_rdata | output | 32 | Current report word |
| rpt_stat_we | input | 1 | Report status write strobe (error clear) |
| rpt_stat_wdata | input | 32 | Report status write data; bit 10 clears the error |
| rpt_status | output | 32 | Report ring status word |

## Verification
Every write, push and pop is registered once, so status words and the consumer record change at the clock edge that takes the strobe. They are due one cycle later. The bench drives strobes just after a falling edge and checks status and record at the next falling edge, after exactly one rising edge. `rpt_rdata` is combinational on the registered head and word position, so the bench samples it in the same cycle as the read strobe, shortly after driving it. The ring reset takes effect on the edge after the control bit is set, so status is checked once the bit has been cleared again.

// File: rtl/dring_pkg.sv
// Shared constants and record types for the descriptor ring queue.
// Assumes 32-bit bus words and a four-word record in both directions.
package dring_pkg;
    localparam int WORD_W    = 32;
    localparam int REC_WORDS = 4;
    localparam int SLOT_W    = 2;
    localparam int ST_RD_LSB = 4;
    localparam int ST_EMPTY  = 8;
    localparam int ST_FULL   = 9;
    localparam int ST_ERR    = 10;
    localparam int CTL_CLR   = 0;

    // Descriptor record, first-written word in the top bits.
    typedef struct packed {
        logic [WORD_W-1:0] addr_lo;
        logic [WORD_W-1:0] addr_hi;
        logic [WORD_W-1:0] len;
        logic [WORD_W-1:0] flags;
    } desc_t;

    // Report record, first-read word in the top bits.
    typedef struct packed {
        logic [WORD_W-1:0] cnt_lo;
        logic [WORD_W-1:0] cnt_hi;
        logic [WORD_W-1:0] aux;
        logic [WORD_W-1:0] flags;
    } rpt_t;

    // Build a packed status word from ring state.
    function automatic logic [WORD_W-1:0] pack_status(
        input logic [SLOT_W-1:0] wr,
        input logic [SLOT_W-1:0] rd,
        input logic              empty,
        input logic              full,
        input logic              err
    );
        logic [WORD_W-1:0] s;
        s = '0;
        s[SLOT_W-1:0]                  = wr;
        s[ST_RD_LSB +: SLOT_W]         = rd;
        s[ST_EMPTY]                    = empty;
        s[ST_FULL]                     = full;
        s[ST_ERR]                      = err;
        return s;
    endfunction
endpackage

// File: rtl/ring_ptrs.sv
// Slot pointers, occupancy, full/empty and sticky error for one ring.
// Assumes callers only request a push or pop when they want one; the
// block itself refuses a push when full and a pop when empty.
module ring_ptrs #(
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic              err_set,
    input  logic              err_clr,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              full,
    output logic              empty,
    output logic              err,
    output logic              push_ok,
    output logic              pop_ok
);
    localparam int DEPTH = 1 << SLOT_W;
    localparam int CNT_W = SLOT_W + 1;

    logic [CNT_W-1:0] cnt;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push_req && !full && !clr;
    assign pop_ok  = pop_req && !empty && !clr;

    // Advance slots and occupancy; ring reset returns to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_slot <= '0;
            rd_slot <= '0;
            cnt     <= '0;
        end else begin
            if (push_ok) wr_slot <= wr_slot + 1'b1;
            if (pop_ok)  rd_slot <= rd_slot + 1'b1;
            cnt <= cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    // Sticky error: setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (err_set || (push_req && full && !clr))
            err <= 1'b1;
        else if (err_clr)
            err <= 1'b0;
    end

    AST_SLOTS_EQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot == rd_slot) |-> (full || empty)); // R4
    AST_FULL_PUSH_KEEPS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !clr) |=> $stable(wr_slot)); // R5
    AST_FULL_PUSH_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !clr) |=> err); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R6
    AST_EMPTY_POP_KEEPS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !clr) |=> $stable(rd_slot)); // R7
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && wr_slot == '0 && rd_slot == '0)); // R8
endmodule

// File: rtl/word_packer.sv
// Gathers NWORDS serial writes from one port into a single record.
// Assumes the ring full flag is registered; words arriving while full
// are refused and reported so the caller can flag an error.
module word_packer #(
    parameter int NWORDS = 4,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     full,
    input  logic                     word_we,
    input  logic [WORD_W-1:0]        word_in,
    output logic                     commit,
    output logic                     bad_word,
    output logic [NWORDS*WORD_W-1:0] rec
);
    localparam int CW   = $clog2(NWORDS);
    localparam int LAST = NWORDS - 1;

    logic [CW-1:0]     wcnt;
    logic              accept;
    logic [WORD_W-1:0] stage [LAST];

    assign accept   = word_we && !full && !clr;
    assign bad_word = word_we && full && !clr;
    assign commit   = accept && (wcnt == CW'(LAST));

    // Track position within the partial record.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            wcnt <= '0;
        else if (accept)
            wcnt <= commit ? '0 : wcnt + 1'b1;
    end

    // One staging register per leading word; the last word is bypassed.
    for (genvar g = 0; g < LAST; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (accept && wcnt == CW'(g))
                stage[g] <= word_in;
        end
        assign rec[(NWORDS-1-g)*WORD_W +: WORD_W] = stage[g];
    end
    assign rec[WORD_W-1:0] = word_in;

    AST_FULL_WORD_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we && full && !clr) |=> $stable(wcnt)); // R5
    AST_COMMIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (wcnt == '0)); // R2
endmodule

// File: rtl/word_unpacker.sv
// Presents one record as NWORDS successive words on a read port.
// Assumes the head record is stable while the ring is not popped.
module word_unpacker #(
    parameter int NWORDS = 4,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     empty,
    input  logic                     rd_en,
    input  logic [NWORDS*WORD_W-1:0] rec,
    output logic [WORD_W-1:0]        rd_data,
    output logic                     pop_req,
    output logic                     bad_read
);
    localparam int CW   = $clog2(NWORDS);
    localparam int LAST = NWORDS - 1;

    logic [CW-1:0]     rcnt;
    logic              take;
    logic [WORD_W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_split
        assign words[g] = rec[(NWORDS-1-g)*WORD_W +: WORD_W];
    end

    assign take     = rd_en && !empty && !clr;
    assign pop_req  = take && (rcnt == CW'(LAST));
    assign bad_read = rd_en && empty && !clr;
    assign rd_data  = empty ? '0 : words[rcnt];

    // Step through the head record, wrapping after its last word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            rcnt <= '0;
        else if (take)
            rcnt <= pop_req ? '0 : rcnt + 1'b1;
    end

    AST_EMPTY_READ_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !clr) |=> $stable(rcnt)); // R10
endmodule

// File: rtl/desc_ring_queue.sv
// Per-channel descriptor ring (host writes words, engine pops records)
// and report ring (engine pushes records, host reads words).
// Assumes a single clock domain and one access per port per cycle.
module desc_ring_queue (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        dsc_we,
    input  logic [31:0] dsc_wdata,
    input  logic        dsc_stat_we,
    input  logic [31:0] dsc_stat_wdata,
    output logic [31:0] dsc_status,
    input  logic        cons_pop,
    output logic        cons_valid,
    output logic [63:0] cons_addr,
    output logic [31:0] cons_len,
    output logic [31:0] cons_flags,
    input  logic        rpt_push,
    input  logic [63:0] rpt_count,
    input  logic [31:0] rpt_aux,
    input  logic [31:0] rpt_flags,
    input  logic        rpt_re,
    output logic [31:0] rpt_rdata,
    input  logic        rpt_stat_we,
    input  logic [31:0] rpt_stat_wdata,
    output logic [31:0] rpt_status
);
    import dring_pkg::*;

    localparam int DEPTH = 1 << SLOT_W;
    localparam int REC_W = REC_WORDS * WORD_W;

    logic ring_clr;
    logic unused_bits;
    assign unused_bits = ^{ctl_wdata[31:1], dsc_stat_wdata[31:11],
                           dsc_stat_wdata[9:0], rpt_stat_wdata[31:11],
                           rpt_stat_wdata[9:0]};

    // Control register: bit 0 holds both rings in reset while set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring_clr <= 1'b0;
        else if (ctl_we)
            ring_clr <= ctl_wdata[CTL_CLR];
    end

    // ---------------- descriptor ring ----------------
    logic              d_commit, d_bad, d_full, d_empty, d_err;
    logic              d_push_ok, d_pop_ok;
    logic [SLOT_W-1:0] d_wr, d_rd;
    logic [REC_W-1:0]  d_rec;
    desc_t             dmem [DEPTH];
    desc_t             d_head;

    word_packer #(.NWORDS(REC_WORDS), .WORD_W(WORD_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr), .full(d_full),
        .word_we(dsc_we), .word_in(dsc_wdata),
        .commit(d_commit), .bad_word(d_bad), .rec(d_rec)
    );

    ring_ptrs #(.SLOT_W(SLOT_W)) u_dptr (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr),
        .push_req(d_commit), .pop_req(cons_pop),
        .err_set(d_bad), .err_clr(dsc_stat_we && dsc_stat_wdata[ST_ERR]),
        .wr_slot(d_wr), .rd_slot(d_rd), .full(d_full), .empty(d_empty),
        .err(d_err), .push_ok(d_push_ok), .pop_ok(d_pop_ok)
    );

    // Store a committed descriptor at the write slot.
    always_ff @(posedge clk) begin
        if (d_push_ok)
            dmem[d_wr] <= desc_t'(d_rec);
    end

    assign d_head     = dmem[d_rd];
    assign cons_valid = !d_empty;
    assign cons_addr  = {d_head.addr_hi, d_head.addr_lo};
    assign cons_len   = d_head.len;
    assign cons_flags = d_head.flags;
    assign dsc_status = pack_status(d_wr, d_rd, d_empty, d_full, d_err);

    // ---------------- report ring ----------------
    logic              r_pop_req, r_bad, r_full, r_empty, r_err;
    logic              r_push_ok, r_pop_ok;
    logic [SLOT_W-1:0] r_wr, r_rd;
    rpt_t              rmem [DEPTH];
    rpt_t              r_in;

    assign r_in = '{cnt_lo: rpt_count[31:0], cnt_hi: rpt_count[63:32],
                    aux: rpt_aux, flags: rpt_flags};

    ring_ptrs #(.SLOT_W(SLOT_W)) u_rptr (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr),
        .push_req(rpt_push), .pop_req(r_pop_req),
        .err_set(r_bad), .err_clr(rpt_stat_we && rpt_stat_wdata[ST_ERR]),
        .wr_slot(r_wr), .rd_slot(r_rd), .full(r_full), .empty(r_empty),
        .err(r_err), .push_ok(r_push_ok), .pop_ok(r_pop_ok)
    );

    // Store a pushed report at the write slot.
    always_ff @(posedge clk) begin
        if (r_push_ok)
            rmem[r_wr] <= r_in;
    end

    word_unpacker #(.NWORDS(REC_WORDS), .WORD_W(WORD_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .clr(ring_clr), .empty(r_empty),
        .rd_en(rpt_re), .rec(REC_W'(rmem[r_rd])),
        .rd_data(rpt_rdata), .pop_req(r_pop_req), .bad_read(r_bad)
    );

    assign rpt_status = pack_status(r_wr, r_rd, r_empty, r_full, r_err);

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        d_pop_ok |-> cons_valid); // R7
    AST_RPT_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_empty |-> (rpt_rdata == '0)); // R10
    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_status[31:11] == '0 && rpt_status[31:11] == '0)); // R3
    AST_RPT_POP_ONLY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        r_pop_ok |-> !r_empty); // R9
endmodule

// File: tb/desc_ring_queue_tb.sv
`timescale 1ns/1ps
module desc_ring_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we, dsc_we, dsc_stat_we, cons_pop, rpt_push, rpt_re, rpt_stat_we;
    logic [31:0] ctl_wdata, dsc_wdata, dsc_stat_wdata, rpt_aux, rpt_flags, rpt_stat_wdata;
    logic [63:0] rpt_count;
    logic [31:0] dsc_status, rpt_status, cons_len, cons_flags, rpt_rdata;
    logic [63:0] cons_addr;
    logic        cons_valid;

    int n_chk = 0, n_fail = 0;
    int mwr = 0, mrd = 0, mcnt = 0; bit merr = 0;
    int rwr = 0, rrd = 0, rcnt = 0; bit rerr = 0;

    always #2.5 clk = ~clk;

    desc_ring_queue u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .dsc_we(dsc_we), .dsc_wdata(dsc_wdata), .dsc_stat_we(dsc_stat_we),
        .dsc_stat_wdata(dsc_stat_wdata), .dsc_status(dsc_status),
        .cons_pop(cons_pop), .cons_valid(cons_valid), .cons_addr(cons_addr),
        .cons_len(cons_len), .cons_flags(cons_flags), .rpt_push(rpt_push),
        .rpt_count(rpt_count), .rpt_aux(rpt_aux), .rpt_flags(rpt_flags),
        .rpt_re(rpt_re), .rpt_rdata(rpt_rdata), .rpt_stat_we(rpt_stat_we),
        .rpt_stat_wdata(rpt_stat_wdata), .rpt_status(rpt_status)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected status from R3/R4 layout.
    function automatic logic [31:0] st(input int wr, input int rd, input int cnt, input bit err);
        return 32'(wr % 4) | (32'(rd % 4) << 4) | (32'(cnt == 0) << 8)
             | (32'(cnt == 4) << 9) | (32'(err) << 10);
    endfunction

    function automatic logic [31:0] dw(input int id, input int j);
        return 32'hA000_0000 + 32'(id * 16 + j);
    endfunction

    task automatic write_word(input logic [31:0] d);
        dsc_we = 1'b1; dsc_wdata = d;
        @(negedge clk);
        dsc_we = 1'b0;
    endtask

    task automatic push_desc(input int id);
        for (int j = 0; j < 4; j++) write_word(dw(id, j));
        mcnt++; mwr++;
    endtask

    task automatic pop_desc(input int id, input string req);
        check({req, " valid"}, 64'(cons_valid), 64'd1);
        check({req, " addr"}, cons_addr, {dw(id, 1), dw(id, 0)});
        check({req, " len"}, 64'(cons_len), 64'(dw(id, 2)));
        check({req, " flags"}, 64'(cons_flags), 64'(dw(id, 3)));
        cons_pop = 1'b1;
        @(negedge clk);
        cons_pop = 1'b0;
        mcnt--; mrd++;
        check({req, " status after pop"}, 64'(dsc_status), 64'(st(mwr, mrd, mcnt, merr)));
    endtask

    task automatic push_rpt(input int id);
        rpt_push = 1'b1;
        rpt_count = {32'hC000_0000 + 32'(id), 32'hB000_0000 + 32'(id)};
        rpt_aux = 32'hD000_0000 + 32'(id);
        rpt_flags = 32'hE000_0000 + 32'(id);
        @(negedge clk);
        rpt_push = 1'b0;
        if (rcnt < 4) begin rcnt++; rwr++; end else rerr = 1;
    endtask

    task automatic read_word(input logic [31:0] exp, input string req);
        rpt_re = 1'b1;
        #1;
        check(req, 64'(rpt_rdata), 64'(exp));
        @(negedge clk);
        rpt_re = 1'b0;
    endtask

    task automatic read_rpt(input int id);
        read_word(32'hB000_0000 + 32'(id), "R9 count low");
        read_word(32'hC000_0000 + 32'(id), "R9 count high");
        read_word(32'hD000_0000 + 32'(id), "R9 aux");
        read_word(32'hE000_0000 + 32'(id), "R9 flags");
        rcnt--; rrd++;
        check("R9 report status after drain", 64'(rpt_status), 64'(st(rwr, rrd, rcnt, rerr)));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int id;
        logic [31:0] s;
        int occ;
        rst_n = 0; ctl_we = 0; dsc_we = 0; dsc_stat_we = 0; cons_pop = 0;
        rpt_push = 0; rpt_re = 0; rpt_stat_we = 0;
        ctl_wdata = 0; dsc_wdata = 0; dsc_stat_wdata = 0; rpt_aux = 0;
        rpt_flags = 0; rpt_stat_wdata = 0; rpt_count = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 desc status", 64'(dsc_status), 64'h100);
        check("R1 report status", 64'(rpt_status), 64'h100);
        check("R1 cons_valid", 64'(cons_valid), 64'd0);
        check("R1 rpt_rdata", 64'(rpt_rdata), 64'd0);

        // R2 partial descriptor does not commit
        for (int j = 0; j < 3; j++) write_word(dw(0, j));
        check("R2 no commit before fourth word", 64'(dsc_status), 64'(st(0, 0, 0, 0)));
        write_word(dw(0, 3));
        mcnt = 1; mwr = 1;
        check("R3 status after one commit", 64'(dsc_status), 64'h0000_0001);
        check("R2 addr", cons_addr, {dw(0, 1), dw(0, 0)});

        // R4 fill to four
        for (int k = 1; k < 4; k++) push_desc(k);
        check("R4 full status", 64'(dsc_status), 64'h200);

        // R5 word while full
        write_word(32'hDEAD_BEEF);
        merr = 1;
        check("R5 error on full write", 64'(dsc_status), 64'h600);

        // R6 sticky error
        dsc_stat_we = 1; dsc_stat_wdata = 32'hFFFF_FBFF;
        @(negedge clk); dsc_stat_we = 0;
        check("R6 zero bit leaves error", 64'(dsc_status), 64'h600);
        dsc_stat_we = 1; dsc_stat_wdata = 32'h400;
        @(negedge clk); dsc_stat_we = 0;
        merr = 0;
        check("R6 error cleared", 64'(dsc_status), 64'h200);

        // R11 order out of a full ring
        for (int k = 0; k < 4; k++) pop_desc(k, "R11 full drain");

        // R5 ignored word did not shift word position
        push_desc(4);
        pop_desc(4, "R5 after ignored word");

        // R4/R11 sweep of occupancy and start slot
        id = 10;
        for (int round = 0; round < 12; round++) begin
            int n;
            n = (round % 4) + 1;
            for (int k = 0; k < n; k++) push_desc(id + k);
            s = dsc_status;
            check("R4 status in sweep", 64'(s), 64'(st(mwr, mrd, mcnt, merr)));
            if (s[1:0] != s[5:4]) occ = (int'(s[1:0]) + 4 - int'(s[5:4])) % 4;
            else occ = s[9] ? 4 : 0;
            check("R4 occupancy from status", 64'(occ), 64'(n));
            for (int k = 0; k < n; k++) pop_desc(id + k, "R11 sweep");
            id += n;
        end

        // R7 pop on empty
        s = dsc_status;
        cons_pop = 1; @(negedge clk); cons_pop = 0;
        check("R7 empty pop ignored", 64'(dsc_status), 64'(s));

        // R7 pop with commit into empty ring
        for (int j = 0; j < 3; j++) write_word(dw(90, j));
        dsc_we = 1; dsc_wdata = dw(90, 3); cons_pop = 1;
        @(negedge clk);
        dsc_we = 0; cons_pop = 0;
        mcnt++; mwr++;
        check("R7 commit kept", 64'(dsc_status), 64'(st(mwr, mrd, mcnt, merr)));
        pop_desc(90, "R7 commit kept");

        // R8 ring reset with entry and partial descriptor present
        push_desc(91);
        write_word(32'h1111_1111); write_word(32'h2222_2222);
        push_rpt(1);
        ctl_we = 1; ctl_wdata = 1; @(negedge clk);
        ctl_wdata = 0; @(negedge clk); ctl_we = 0;
        mwr = 0; mrd = 0; mcnt = 0; rwr = 0; rrd = 0; rcnt = 0;
        check("R8 desc ring reset", 64'(dsc_status), 64'h100);
        check("R8 report ring reset", 64'(rpt_status), 64'h100);
        push_desc(92);
        pop_desc(92, "R8 partial discarded");

        // R9 report words
        push_rpt(20); push_rpt(21);
        check("R9 report status two", 64'(rpt_status), 64'(st(2, 0, 2, 0)));
        read_rpt(20); read_rpt(21);

        // R10 read on empty
        read_word(32'h0, "R10 empty read data");
        rerr = 1;
        check("R10 empty read error", 64'(rpt_status), 64'(st(rwr, rrd, rcnt, rerr)));
        rpt_stat_we = 1; rpt_stat_wdata = 32'h400; @(negedge clk); rpt_stat_we = 0;
        rerr = 0;
        check("R6 report error cleared", 64'(rpt_status), 64'(st(rwr, rrd, rcnt, rerr)));

        // R10 push while full is dropped
        for (int k = 0; k < 5; k++) push_rpt(30 + k);
        check("R10 full push error", 64'(rpt_status), 64'(st(rwr, rrd, 4, 1)));
        for (int k = 0; k < 4; k++) read_rpt(30 + k);
        check("R10 dropped record absent", 64'(rpt_rdata), 64'd0);

        finish_run();
    end
endmodule